// File: doc/BRIEF.md
# Raster Timing Generator with Cumulative Boundary Registers

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel. It also reports the current pixel and line position and raises a one-cycle line interrupt. It runs one step per clock of the pixel clock domain. Each dimension is programmed as a set of running end positions rather than separate segment lengths. The sync field holds the sync length less one. The porch field adds the back porch to that value. The active field adds the visible span. The total field adds the front porch.

Software writes timing values into a shadow copy through a small write port. The generator keeps using its working copy until a reload is requested. A reload can be immediate, or it can be held back to the frame boundary so that a running picture never sees a frame with mixed geometry. A control word sets the global enable, the level of each strobe and a pixel-clock inversion flag for the clock logic outside this block.

Top module: `tg_timing_gen`

## Requirements
- R1: Address 0 is the sync word, 1 the porch word, 2 the active word and 3 the total word. In each of these words the horizontal end position is bits 27:16 and the vertical end position is bits 10:0. Address 5 takes the interrupt line in bits 10:0.
- R2: Bit 0 of the control word at address 4 enables the generator. While it is clear, both counters are held at 0, every strobe sits at its inactive level and the line interrupt stays low.
- R3: While enabled, pos_x counts up from 0 through the horizontal total, then returns to 0 and advances pos_y. pos_y returns to 0 after the line equal to the vertical total.
- R4: The horizontal sync is active while pos_x is at or below the horizontal sync field. The vertical sync is active while pos_y is at or below the vertical sync field.
- R5: DE is active when pos_x is above the horizontal porch field and at or below the horizontal active field, and pos_y is likewise above the vertical porch field and at or below the vertical active field.
- R6: Control bit 31 makes the horizontal sync active-high, bit 30 makes the vertical sync active-high and bit 29 makes DE active-high. A clear bit makes that strobe active-low. Bit 28 is driven on pclk_inv_o.
- R7: line_irq_o pulses for one cycle at pos_x = 0 of the line whose number equals the programmed interrupt line, while enabled.
- R8: Writes to addresses 0, 1, 2, 3 and 5 land in shadow storage. The working timing is unchanged until a reload takes effect.
- R9: Writing address 6 with bit 0 set raises reload_pend_o[0] on the next cycle. The copy into the working set happens at the following clock edge, and the bit clears at that same edge.
- R10: Writing address 6 with bit 1 set raises reload_pend_o[1], which stays set until the last pixel of the frame (pos_x at the horizontal total and pos_y at the vertical total). The copy happens at that edge, so the next frame uses the new values. While the generator is disabled, the copy happens at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Register write value |
| hsync_o | output | 1 | Horizontal sync at programmed level |
| vsync_o | output | 1 | Vertical sync at programmed level |
| de_o | output | 1 | Data enable at programmed level |
| pclk_inv_o | output | 1 | Pixel clock inversion request |
| pos_x | output | 12 | Current pixel position in the line |
| pos_y | output | 11 | Current line position in the frame |
| line_irq_o | output | 1 | One-cycle line interrupt pulse |
| reload_pend_o | output | 2 | Pending reload requests {blanking, immediate} |

## Verification
The bench targets the off-by-one edges of the cumulative encoding. A design that compares with < instead of <= would drop the last sync column and the last visible pixel, and the DE pixel count per frame would come up short. A reload held for blanking that fires early would produce one frame with mixed line lengths, or a line longer than the old total before the pending flag clears. A copy that ignores the shadow would change the line length as soon as the words are written. Disabling mid-frame and a blanking reload issued while idle check that the counters collapse to zero and that an idle generator does not leave the request waiting for a frame end that never comes.

// File: rtl/tg_pkg.sv
`timescale 1ns/1ps
package tg_pkg;
    parameter int H_BITS = 12;
    parameter int V_BITS = 11;
    parameter int DATA_W = 32;
    parameter int ADDR_W = 3;

    localparam int H_LSB         = 16;
    localparam int V_LSB         = 0;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_PCLK_BIT = 28;
    localparam int CTRL_DE_BIT   = 29;
    localparam int CTRL_VS_BIT   = 30;
    localparam int CTRL_HS_BIT   = 31;
    localparam int RLD_NOW_BIT   = 0;
    localparam int RLD_VBL_BIT   = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_SYNC   = 3'd0,
        A_PORCH  = 3'd1,
        A_ACTIVE = 3'd2,
        A_TOTAL  = 3'd3,
        A_CTRL   = 3'd4,
        A_LINE   = 3'd5,
        A_RELOAD = 3'd6
    } tg_addr_e;

    typedef struct packed {
        logic [H_BITS-1:0] h;
        logic [V_BITS-1:0] v;
    } tg_pair_t;

    typedef struct packed {
        tg_pair_t          sync;
        tg_pair_t          porch;
        tg_pair_t          active;
        tg_pair_t          total;
        logic [V_BITS-1:0] irq_line;
    } tg_timing_t;

    typedef struct packed {
        logic en;
        logic hs_high;
        logic vs_high;
        logic de_high;
        logic pclk_inv;
    } tg_ctrl_t;

    function automatic tg_pair_t unpack_pair(input logic [DATA_W-1:0] w);
        tg_pair_t p;
        p.h = w[H_LSB +: H_BITS];
        p.v = w[V_LSB +: V_BITS];
        return p;
    endfunction

    function automatic logic drive_level(input logic active, input logic high_act);
        return high_act ? active : ~active;
    endfunction
endpackage

// File: rtl/tg_regs.sv
`timescale 1ns/1ps
module tg_regs
    import tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_end,
    output tg_timing_t        act,
    output tg_ctrl_t          ctrl,
    output logic [1:0]        pend
);
    tg_timing_t shd;
    logic       rld_wr;
    logic       now_fire;
    logic       vbl_fire;
    logic       unused_bits;

    assign unused_bits = ^wr_data[15:11];
    assign rld_wr   = wr_en && (wr_addr == A_RELOAD);
    assign now_fire = pend[RLD_NOW_BIT];
    assign vbl_fire = pend[RLD_VBL_BIT] && (!ctrl.en || frame_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            shd <= '0;
        end else if (wr_en) begin
            case (tg_addr_e'(wr_addr))
                A_SYNC:   shd.sync     <= unpack_pair(wr_data);
                A_PORCH:  shd.porch    <= unpack_pair(wr_data);
                A_ACTIVE: shd.active   <= unpack_pair(wr_data);
                A_TOTAL:  shd.total    <= unpack_pair(wr_data);
                A_LINE:   shd.irq_line <= wr_data[V_LSB +: V_BITS];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && (wr_addr == A_CTRL)) begin
            ctrl.en       <= wr_data[CTRL_EN_BIT];
            ctrl.hs_high  <= wr_data[CTRL_HS_BIT];
            ctrl.vs_high  <= wr_data[CTRL_VS_BIT];
            ctrl.de_high  <= wr_data[CTRL_DE_BIT];
            ctrl.pclk_inv <= wr_data[CTRL_PCLK_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= '0;
        end else if (now_fire || vbl_fire) begin
            act <= shd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            if (rld_wr && wr_data[RLD_NOW_BIT])
                pend[RLD_NOW_BIT] <= 1'b1;
            else if (now_fire)
                pend[RLD_NOW_BIT] <= 1'b0;

            if (rld_wr && wr_data[RLD_VBL_BIT])
                pend[RLD_VBL_BIT] <= 1'b1;
            else if (vbl_fire)
                pend[RLD_VBL_BIT] <= 1'b0;
        end
    end
endmodule

// File: rtl/tg_counters.sv
`timescale 1ns/1ps
module tg_counters
    import tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  tg_pair_t          total,
    output logic [H_BITS-1:0] x,
    output logic [V_BITS-1:0] y,
    output logic              frame_end
);
    logic line_end;
    logic last_line;

    assign line_end  = (x >= total.h);
    assign last_line = (y >= total.v);
    assign frame_end = en && (x == total.h) && (y == total.v);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            x <= '0;
            y <= '0;
        end else if (line_end) begin
            x <= '0;
            y <= last_line ? '0 : y + 1'b1;
        end else begin
            x <= x + 1'b1;
        end
    end
endmodule

// File: rtl/tg_decode.sv
`timescale 1ns/1ps
module tg_decode
    import tg_pkg::*;
(
    input  logic              en,
    input  logic [H_BITS-1:0] x,
    input  logic [V_BITS-1:0] y,
    input  tg_pair_t          sync,
    input  tg_pair_t          porch,
    input  tg_pair_t          active,
    input  logic [V_BITS-1:0] irq_line,
    output logic              hs_act,
    output logic              vs_act,
    output logic              de_act,
    output logic              irq
);
    logic h_vis;
    logic v_vis;

    always_comb begin
        h_vis  = (x > porch.h) && (x <= active.h);
        v_vis  = (y > porch.v) && (y <= active.v);
        hs_act = en && (x <= sync.h);
        vs_act = en && (y <= sync.v);
        de_act = en && h_vis && v_vis;
        irq    = en && (x == '0) && (y == irq_line);
    end
endmodule

// File: rtl/tg_timing_gen.sv
`timescale 1ns/1ps
module tg_timing_gen
    import tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              pclk_inv_o,
    output logic [H_BITS-1:0] pos_x,
    output logic [V_BITS-1:0] pos_y,
    output logic              line_irq_o,
    output logic [1:0]        reload_pend_o
);
    tg_timing_t act_q;
    tg_ctrl_t   ctrl_q;
    logic [1:0] pend_q;
    logic       frame_end;
    logic       hs_act, vs_act, de_act, irq;

    tg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .frame_end (frame_end),
        .act       (act_q),
        .ctrl      (ctrl_q),
        .pend      (pend_q)
    );

    tg_counters u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl_q.en),
        .total     (act_q.total),
        .x         (pos_x),
        .y         (pos_y),
        .frame_end (frame_end)
    );

    tg_decode u_dec (
        .en       (ctrl_q.en),
        .x        (pos_x),
        .y        (pos_y),
        .sync     (act_q.sync),
        .porch    (act_q.porch),
        .active   (act_q.active),
        .irq_line (act_q.irq_line),
        .hs_act   (hs_act),
        .vs_act   (vs_act),
        .de_act   (de_act),
        .irq      (irq)
    );

    assign hsync_o       = drive_level(hs_act, ctrl_q.hs_high);
    assign vsync_o       = drive_level(vs_act, ctrl_q.vs_high);
    assign de_o          = drive_level(de_act, ctrl_q.de_high);
    assign pclk_inv_o    = ctrl_q.pclk_inv;
    assign line_irq_o    = irq;
    assign reload_pend_o = pend_q;
endmodule

// File: rtl/tg_timing_gen_chk.sv
`timescale 1ns/1ps
module tg_timing_gen_chk
    import tg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input tg_ctrl_t          ctrl,
    input tg_timing_t        act,
    input logic [H_BITS-1:0] x,
    input logic [V_BITS-1:0] y,
    input logic              frame_end,
    input logic [1:0]        pend,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_now
);
    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && (x >= act.total.h)) |=> (x == '0));

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |=> ((x == '0) && (y == '0)));

    assert_now_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (pend[0] && !(wr_en && (wr_addr == A_RELOAD) && wr_now)) |=> !pend[0]);

    assert_vbl_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (pend[1] && ctrl.en && !frame_end) |=> pend[1]);

    assert_shadow_R8: assert property (@(posedge clk) disable iff (rst)
        (!pend[0] && !(pend[1] && (!ctrl.en || frame_end))) |=> $stable(act));
endmodule

bind tg_timing_gen tg_timing_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl_q),
    .act       (act_q),
    .x         (pos_x),
    .y         (pos_y),
    .frame_end (frame_end),
    .pend      (pend_q),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_now    (wr_data[0])
);

// File: tb/tg_timing_gen_bench.sv
`timescale 1ns/1ps
module tg_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync_o, vsync_o, de_o, pclk_inv_o, line_irq_o;
    logic [11:0] pos_x;
    logic [10:0] pos_y;
    logic [1:0]  reload_pend_o;

    int nchk = 0;
    int nerr = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    tg_timing_gen u_tg_timing_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pclk_inv_o(pclk_inv_o),
        .pos_x(pos_x), .pos_y(pos_y), .line_irq_o(line_irq_o), .reload_pend_o(reload_pend_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        int hsw, ahbp, aaw, totw, vsh, avbp, aah, toth, lpos;
    } cfg_t;

    cfg_t m_act, m_shd;
    int   mx, my, nx, ny;
    bit   m_en, m_hh, m_vh, m_dh, m_pc, m_p0, m_p1;
    bit   fe, f_now, f_vbl;
    bit   e_hs, e_vs, e_de, e_irq;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model built from R1-style field rules, stepped on every edge
    always @(posedge clk) begin
        if (rst) begin
            m_act = '{default: 0};
            m_shd = '{default: 0};
            mx = 0; my = 0;
            m_en = 0; m_hh = 0; m_vh = 0; m_dh = 0; m_pc = 0; m_p0 = 0; m_p1 = 0;
        end else begin
            fe    = m_en && mx == m_act.totw && my == m_act.toth;
            f_now = m_p0;
            f_vbl = m_p1 && (!m_en || fe);
            if (!m_en) begin
                nx = 0; ny = 0;
            end else if (mx >= m_act.totw) begin
                nx = 0;
                ny = (my >= m_act.toth) ? 0 : my + 1;
            end else begin
                nx = mx + 1; ny = my;
            end
            if (f_now || f_vbl) m_act = m_shd;
            if (f_now) m_p0 = 0;
            if (f_vbl) m_p1 = 0;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_shd.hsw  = int'(wr_data[27:16]); m_shd.vsh  = int'(wr_data[10:0]); end
                    3'd1: begin m_shd.ahbp = int'(wr_data[27:16]); m_shd.avbp = int'(wr_data[10:0]); end
                    3'd2: begin m_shd.aaw  = int'(wr_data[27:16]); m_shd.aah  = int'(wr_data[10:0]); end
                    3'd3: begin m_shd.totw = int'(wr_data[27:16]); m_shd.toth = int'(wr_data[10:0]); end
                    3'd4: begin
                        m_en = wr_data[0]; m_pc = wr_data[28]; m_dh = wr_data[29];
                        m_vh = wr_data[30]; m_hh = wr_data[31];
                    end
                    3'd5: m_shd.lpos = int'(wr_data[10:0]);
                    3'd6: begin
                        if (wr_data[0]) m_p0 = 1;
                        if (wr_data[1]) m_p1 = 1;
                    end
                    default: ;
                endcase
            end
            mx = nx; my = ny;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            e_hs  = m_en && mx <= m_act.hsw;
            e_vs  = m_en && my <= m_act.vsh;
            e_de  = m_en && mx > m_act.ahbp && mx <= m_act.aaw && my > m_act.avbp && my <= m_act.aah;
            e_irq = m_en && mx == 0 && my == m_act.lpos;
            if (!m_hh) e_hs = !e_hs;
            if (!m_vh) e_vs = !e_vs;
            if (!m_dh) e_de = !e_de;
            chk(int'(pos_x) == mx, "R3 pos_x", int'(pos_x), mx);
            chk(int'(pos_y) == my, "R3 pos_y", int'(pos_y), my);
            chk(hsync_o == e_hs, "R4/R6 hsync", int'(hsync_o), int'(e_hs));
            chk(vsync_o == e_vs, "R4/R6 vsync", int'(vsync_o), int'(e_vs));
            chk(de_o == e_de, "R5/R6 de", int'(de_o), int'(e_de));
            chk(pclk_inv_o == m_pc, "R6 pclk_inv", int'(pclk_inv_o), int'(m_pc));
            chk(line_irq_o == e_irq, "R7 line_irq", int'(line_irq_o), int'(e_irq));
            chk(reload_pend_o == {m_p1, m_p0}, "R9/R10 pending", int'(reload_pend_o), int'({m_p1, m_p0}));
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] pair(input int h, input int v);
        return (32'(h) << 16) | 32'(v);
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(pos_x == 0 && pos_y == 0, "R2 reset position", int'(pos_x) + int'(pos_y), 0);
        chk(hsync_o == 1 && vsync_o == 1 && de_o == 1, "R2 reset inactive low-active levels",
            int'({hsync_o, vsync_o, de_o}), 7);
        chk(line_irq_o == 0, "R7 reset irq", int'(line_irq_o), 0);
        chk(reload_pend_o == 0, "R9 reset pending", int'(reload_pend_o), 0);
        rst = 1'b0;
        cmp_on = 1'b1;
    endtask

    task automatic t_shadow_only();
        wr(0, pair(1, 0));
        wr(1, pair(3, 1));
        wr(2, pair(7, 4));
        wr(3, pair(9, 5));
        wr(5, 32'd5);
        wr(4, 32'hE000_0001);
        repeat (12) begin
            @(negedge clk);
            chk(pos_x == 0 && pos_y == 0, "R8 shadow not yet active", int'(pos_x), 0);
        end
        wr(4, 32'h0000_0000);
    endtask

    task automatic t_now_reload();
        int de_cnt = 0;
        int irq_cnt = 0;
        wr(6, 32'd1);
        chk(reload_pend_o == 2'b01, "R9 immediate pending visible", int'(reload_pend_o), 1);
        @(negedge clk);
        chk(reload_pend_o == 2'b00, "R9 immediate pending cleared", int'(reload_pend_o), 0);
        wr(4, 32'hE000_0001);
        for (int i = 0; i < 130; i++) begin
            if (de_o) de_cnt++;
            if (line_irq_o) irq_cnt++;
            @(negedge clk);
        end
        chk(de_cnt == 24, "R5 visible pixels in two frames", de_cnt, 24);
        chk(irq_cnt == 2, "R7 interrupts in two frames", irq_cnt, 2);
    endtask

    task automatic t_vbl_reload();
        int max_x = 0;
        int early = 0;
        wr(2, pair(9, 4));
        wr(3, pair(11, 5));
        wr(6, 32'd2);
        chk(reload_pend_o == 2'b10, "R10 blanking pending visible", int'(reload_pend_o), 2);
        for (int i = 0; i < 140; i++) begin
            @(negedge clk);
            if (reload_pend_o[1] && pos_x > 9) early++;
            if (int'(pos_x) > max_x) max_x = int'(pos_x);
        end
        chk(early == 0, "R10 old geometry kept while pending", early, 0);
        chk(max_x == 11, "R10 new line length after frame end", max_x, 11);
        chk(reload_pend_o == 2'b00, "R10 blanking pending cleared", int'(reload_pend_o), 0);
    endtask

    task automatic t_disable_and_idle_reload();
        int de_cnt = 0;
        int irq_cnt = 0;
        wr(4, 32'hE000_0000);
        @(negedge clk);
        chk(pos_x == 0 && pos_y == 0, "R2 counters cleared on disable", int'(pos_x) + int'(pos_y), 0);
        chk(hsync_o == 0 && vsync_o == 0 && de_o == 0, "R2 idle levels with high polarity",
            int'({hsync_o, vsync_o, de_o}), 0);
        wr(2, pair(7, 4));
        wr(3, pair(9, 5));
        wr(6, 32'd2);
        chk(reload_pend_o == 2'b10, "R10 idle blanking pending visible", int'(reload_pend_o), 2);
        @(negedge clk);
        chk(reload_pend_o == 2'b00, "R10 idle blanking applied next edge", int'(reload_pend_o), 0);
        wr(4, 32'h1000_0001);
        chk(pclk_inv_o == 1'b1, "R6 pixel clock inversion", int'(pclk_inv_o), 1);
        for (int i = 0; i < 130; i++) begin
            if (!de_o) de_cnt++;
            if (line_irq_o) irq_cnt++;
            @(negedge clk);
        end
        chk(de_cnt == 24, "R5/R6 active-low DE pixel count", de_cnt, 24);
        chk(irq_cnt == 2, "R7 interrupts with low polarity", irq_cnt, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_shadow_only();
        t_now_reload();
        t_vbl_reload();
        t_disable_and_idle_reload();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule